// File: doc/BRIEF.md
# GPIO Expander Register Core

This block holds the register state of an eight-pin general purpose I/O expander that is reached over a two-wire serial bus. A byte-level slave front end, not part of this block, turns bus activity into single-cycle strobes. These mark a start or repeated start, a stop, an address match carrying the read/write bit, a byte received with its value, and a request for a byte to transmit. The block decodes these strobes into register writes and reads. It drives the pin output values and enables, the pull resistor controls, a polarity-adjusted image of the pins and an interrupt line.

A write transaction carries a command byte after the address. The low three bits of that byte set a register pointer, and any further bytes in the same transaction are written to the register it selects. A read is made by setting the pointer in a write transaction, then issuing a repeated start with the read bit set. The pointer is kept between transactions, so later reads may skip the command byte. The pins are brought in through a two-stage synchronizer. An input change on an unmasked pin latches a status bit and raises the interrupt, and a read of the input register clears it.

Top module: `gpx_regfile`

## Requirements
- R1: In a write transaction, the first byte after the address loads the register pointer from its bits [2:0], and bits [7:3] are ignored. Pointer values: 0 input image, 1 polarity, 2 pull enable, 3 pull select, 4 direction, 5 output data, 6 interrupt mask, 7 interrupt status.
- R2: After reset, direction is 0xFF, polarity 0x00, pull enable 0x00, pull select 0xFF, output data 0x00, interrupt mask 0xFF, interrupt status 0x00 and pointer 0. So pin_oe is 0x00, pin_out is 0x00 and irq is 0.
- R3: A direction bit of 1 makes its pin an input (pin_oe bit 0), and 0 makes it an output (pin_oe bit 1).
- R4: pin_out carries the output data bit on output pins and 0 on input pins. Output data written while a pin is an input appears on pin_out once the pin is made an output.
- R5: in_image equals the synchronized pins XOR the polarity register, where a polarity bit of 1 inverts. A pin change set up before clock edge k shows on in_image after edge k+1.
- R6: Writes to pointer 0 and pointer 7 change no register.
- R7: Every data byte of one write transaction goes to the same selected register, and the last one stays. The pointer keeps its value across transactions, including a read that has no command byte.
- R8: A byte request in the read phase of a transaction loads tx_byte with the selected register, valid from the next clock edge.
- R9: A status bit is set when the synchronized pin changes and its mask bit is 0. A mask bit of 1 blocks it. irq is 1 whenever any status bit is 1.
- R10: A read of pointer 0 clears the interrupt status. A change detected in the same cycle as that read leaves its bit set.
- R11: Writing one register leaves every other register unchanged.
- R12: pull_en and pull_sel present the pull enable and pull select registers, where a pull select bit of 1 means pull-up and 0 means pull-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_stb | input | 1 | Start or repeated start seen |
| stop_stb | input | 1 | Stop seen |
| addr_stb | input | 1 | Slave address matched |
| addr_rw | input | 1 | Read/write bit with addr_stb, 1 = read |
| rx_stb | input | 1 | Data byte received |
| rx_byte | input | 8 | Received byte |
| req_stb | input | 1 | Front end requests a byte to send |
| tx_byte | output | 8 | Byte to send |
| pin_in | input | 8 | Pin levels, asynchronous |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin drive enables, 1 = drive |
| pull_en | output | 8 | Pull resistor enable per pin |
| pull_sel | output | 8 | Pull direction per pin, 1 = up |
| in_image | output | 8 | Polarity-adjusted synchronized pins |
| irq | output | 1 | Interrupt, active high |

## Verification
The clear that comes with reading the input register and the setting of a status bit by a freshly synchronized pin change can fall on the same clock edge. The bench provokes this by changing one unmasked pin while an older status bit is pending, then timing the byte request to land exactly on the edge where the new change registers. It then judges that the returned byte shows the new pin image, that irq stays high, that a following status read shows only the new bit, and that a second input read brings irq low.

// File: rtl/gpx_pkg.sv
`timescale 1ns/1ps
package gpx_pkg;
    parameter int unsigned BYTE_W  = 8;
    parameter int unsigned PTR_W   = 3;
    parameter int unsigned SYNC_STAGES = 2;
    localparam int unsigned NUM_REGS = 1 << PTR_W;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [PTR_W-1:0] {
        IDX_INPUT    = 3'd0,
        IDX_POLARITY = 3'd1,
        IDX_PULL_EN  = 3'd2,
        IDX_PULL_SEL = 3'd3,
        IDX_CONFIG   = 3'd4,
        IDX_OUTPUT   = 3'd5,
        IDX_IRQ_MASK = 3'd6,
        IDX_IRQ_STAT = 3'd7
    } reg_idx_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CMD,
        PH_WDATA,
        PH_RDATA
    } phase_e;

    typedef struct packed {
        logic     en;
        reg_idx_e idx;
        byte_t    data;
    } wr_req_t;

    typedef struct packed {
        byte_t pol;
        byte_t pen;
        byte_t psel;
        byte_t cfg;
        byte_t outp;
        byte_t mask;
    } ctrl_regs_t;

    localparam byte_t DEF_POL  = '0;
    localparam byte_t DEF_PEN  = '0;
    localparam byte_t DEF_PSEL = '1;
    localparam byte_t DEF_CFG  = '1;
    localparam byte_t DEF_OUTP = '0;
    localparam byte_t DEF_MASK = '1;

    function automatic ctrl_regs_t regs_default();
        ctrl_regs_t r;
        r.pol  = DEF_POL;
        r.pen  = DEF_PEN;
        r.psel = DEF_PSEL;
        r.cfg  = DEF_CFG;
        r.outp = DEF_OUTP;
        r.mask = DEF_MASK;
        return r;
    endfunction

    function automatic logic is_read_only(reg_idx_e i);
        return (i == IDX_INPUT) || (i == IDX_IRQ_STAT);
    endfunction

    function automatic reg_idx_e ptr_from_cmd(byte_t cmd);
        return reg_idx_e'(cmd[PTR_W-1:0]);
    endfunction
endpackage

// File: rtl/gpx_xfer_ctrl.sv
`timescale 1ns/1ps
module gpx_xfer_ctrl
    import gpx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_stb,
    input  logic     stop_stb,
    input  logic     addr_stb,
    input  logic     addr_rw,
    input  logic     rx_stb,
    input  byte_t    rx_byte,
    input  logic     req_stb,
    output reg_idx_e ptr,
    output wr_req_t  wr,
    output logic     rd_stb
);
    phase_e phase_q;
    logic   frame_edge;

    assign frame_edge = start_stb | stop_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            ptr     <= IDX_INPUT;
        end else if (frame_edge) begin
            phase_q <= PH_IDLE;
        end else if (addr_stb) begin
            phase_q <= addr_rw ? PH_RDATA : PH_CMD;
        end else if (rx_stb && phase_q == PH_CMD) begin
            ptr     <= ptr_from_cmd(rx_byte);
            phase_q <= PH_WDATA;
        end
    end

    always_comb begin
        wr.en   = rx_stb && !frame_edge && !addr_stb && (phase_q == PH_WDATA);
        wr.idx  = ptr;
        wr.data = rx_byte;
        rd_stb  = req_stb && !frame_edge && (phase_q == PH_RDATA);
    end

    // R1: command byte loads the pointer from its low bits
    a_r1_ptr_from_cmd: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CMD && rx_stb && !frame_edge && !addr_stb)
        |=> (ptr == reg_idx_e'($past(rx_byte[PTR_W-1:0]))));

    // R7: a read address phase keeps the pointer
    a_r7_ptr_kept: assert property (@(posedge clk) disable iff (rst)
        (addr_stb && addr_rw && !frame_edge) |=> $stable(ptr));
endmodule

// File: rtl/gpx_reg_bank.sv
`timescale 1ns/1ps
module gpx_reg_bank
    import gpx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_req_t    wr,
    output ctrl_regs_t regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= regs_default();
        end else if (wr.en && !is_read_only(wr.idx)) begin
            case (wr.idx)
                IDX_POLARITY: regs.pol  <= wr.data;
                IDX_PULL_EN:  regs.pen  <= wr.data;
                IDX_PULL_SEL: regs.psel <= wr.data;
                IDX_CONFIG:   regs.cfg  <= wr.data;
                IDX_OUTPUT:   regs.outp <= wr.data;
                IDX_IRQ_MASK: regs.mask <= wr.data;
                default: ;
            endcase
        end
    end

    // R6: writes aimed at read-only pointers leave the bank untouched
    a_r6_ro_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr.en && is_read_only(wr.idx)) |=> $stable(regs));

    // R11: a polarity write leaves the other registers as they were
    a_r11_isolated_write: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.idx == IDX_POLARITY)
        |=> $stable({regs.pen, regs.psel, regs.cfg, regs.outp, regs.mask}));
endmodule

// File: rtl/gpx_pin_sync.sv
`timescale 1ns/1ps
module gpx_pin_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [STAGES-1:0][W-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpx_irq.sv
`timescale 1ns/1ps
module gpx_irq
    import gpx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  byte_t in_sync,
    input  byte_t mask,
    input  logic  clr_stb,
    output byte_t change,
    output byte_t status,
    output logic  irq
);
    byte_t prev_q;

    assign change = in_sync ^ prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            status <= '0;
        end else begin
            prev_q <= in_sync;
            status <= (clr_stb ? '0 : status) | (change & ~mask);
        end
    end

    assign irq = |status;

    // R9: a masked bit never becomes set
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (status & ~$past(status) & $past(mask)) == '0);

    // R10: a clearing read with no new change empties the status
    a_r10_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (clr_stb && change == '0) |=> (status == '0));
endmodule

// File: rtl/gpx_regfile.sv
`timescale 1ns/1ps
module gpx_regfile
    import gpx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_stb,
    input  logic        stop_stb,
    input  logic        addr_stb,
    input  logic        addr_rw,
    input  logic        rx_stb,
    input  logic [7:0]  rx_byte,
    input  logic        req_stb,
    output logic [7:0]  tx_byte,
    input  logic [7:0]  pin_in,
    output logic [7:0]  pin_out,
    output logic [7:0]  pin_oe,
    output logic [7:0]  pull_en,
    output logic [7:0]  pull_sel,
    output logic [7:0]  in_image,
    output logic        irq
);
    reg_idx_e   ptr;
    wr_req_t    wr;
    logic       rd_stb;
    ctrl_regs_t regs;
    byte_t      in_sync;
    byte_t      change;
    byte_t      status;
    byte_t      rd_mux;
    logic       clr_stb;

    gpx_xfer_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_stb (start_stb),
        .stop_stb  (stop_stb),
        .addr_stb  (addr_stb),
        .addr_rw   (addr_rw),
        .rx_stb    (rx_stb),
        .rx_byte   (rx_byte),
        .req_stb   (req_stb),
        .ptr       (ptr),
        .wr        (wr),
        .rd_stb    (rd_stb)
    );

    gpx_reg_bank u_bank (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .regs (regs)
    );

    gpx_pin_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .q_sync  (in_sync)
    );

    assign clr_stb = rd_stb && (ptr == IDX_INPUT);

    gpx_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .in_sync (in_sync),
        .mask    (regs.mask),
        .clr_stb (clr_stb),
        .change  (change),
        .status  (status),
        .irq     (irq)
    );

    assign in_image = in_sync ^ regs.pol;
    assign pin_oe   = ~regs.cfg;
    assign pin_out  = regs.outp & ~regs.cfg;
    assign pull_en  = regs.pen;
    assign pull_sel = regs.psel;

    always_comb begin
        case (ptr)
            IDX_INPUT:    rd_mux = in_image;
            IDX_POLARITY: rd_mux = regs.pol;
            IDX_PULL_EN:  rd_mux = regs.pen;
            IDX_PULL_SEL: rd_mux = regs.psel;
            IDX_CONFIG:   rd_mux = regs.cfg;
            IDX_OUTPUT:   rd_mux = regs.outp;
            IDX_IRQ_MASK: rd_mux = regs.mask;
            default:      rd_mux = status;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         tx_byte <= '0;
        else if (rd_stb) tx_byte <= rd_mux;
    end

    // R2: leaving reset, every pin is undriven and no interrupt is pending
    a_r2_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == '0 && pin_out == '0 && irq == 1'b0));
endmodule

// File: tb/gpx_regfile_bench.sv
`timescale 1ns/1ps
module gpx_regfile_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       start_stb, stop_stb, addr_stb, addr_rw, rx_stb, req_stb;
    logic [7:0] rx_byte, tx_byte, pin_in, pin_out, pin_oe;
    logic [7:0] pull_en, pull_sel, in_image;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    // reference copies of the register contents
    logic [7:0] m_pol, m_pen, m_psel, m_cfg, m_outp, m_mask;

    always #2.5 clk = ~clk;

    gpx_regfile u_gpx_regfile (
        .clk(clk), .rst(rst),
        .start_stb(start_stb), .stop_stb(stop_stb),
        .addr_stb(addr_stb), .addr_rw(addr_rw),
        .rx_stb(rx_stb), .rx_byte(rx_byte),
        .req_stb(req_stb), .tx_byte(tx_byte),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pull_en(pull_en), .pull_sel(pull_sel),
        .in_image(in_image), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    // monitor: scoreboard pops one expected byte per byte request
    always begin
        @(posedge clk);
        if (req_stb && !rst) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
                chk("R8 unexpected read", tx_byte, 8'hxx);
            end else begin
                chk(tag_q.pop_front(), tx_byte, exp_q.pop_front());
            end
        end
    end

    task automatic t_start; start_stb = 1; @(negedge clk); start_stb = 0; endtask
    task automatic t_stop;  stop_stb  = 1; @(negedge clk); stop_stb  = 0; endtask
    task automatic t_addr(input logic rw);
        addr_rw = rw; addr_stb = 1; @(negedge clk); addr_stb = 0;
    endtask
    task automatic t_byte(input logic [7:0] b);
        rx_byte = b; rx_stb = 1; @(negedge clk); rx_stb = 0;
    endtask
    task automatic t_req(input string tag, input logic [7:0] e);
        exp_q.push_back(e); tag_q.push_back(tag);
        req_stb = 1; @(negedge clk); req_stb = 0;
    endtask

    task automatic write_reg(input logic [7:0] cmd, input logic [7:0] d);
        t_start; t_addr(0); t_byte(cmd); t_byte(d); t_stop;
    endtask
    task automatic read_reg(input logic [7:0] cmd, input logic [7:0] e, input string tag);
        t_start; t_addr(0); t_byte(cmd); t_start; t_addr(1); t_req(tag, e); t_stop;
    endtask

    task automatic read_all(input string tag, input logic [7:0] img, input logic [7:0] st);
        read_reg(0, img,    {tag, " in"});
        read_reg(1, m_pol,  {tag, " pol"});
        read_reg(2, m_pen,  {tag, " pen"});
        read_reg(3, m_psel, {tag, " psel"});
        read_reg(4, m_cfg,  {tag, " cfg"});
        read_reg(5, m_outp, {tag, " out"});
        read_reg(6, m_mask, {tag, " mask"});
        read_reg(7, st,     {tag, " stat"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; start_stb = 0; stop_stb = 0; addr_stb = 0; addr_rw = 0;
        rx_stb = 0; rx_byte = 0; req_stb = 0; pin_in = 8'h00;
        m_pol = 8'h00; m_pen = 8'h00; m_psel = 8'hFF;
        m_cfg = 8'hFF; m_outp = 8'h00; m_mask = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 0;

        // R2: reset state at the ports and in every register
        chk("R2 pin_oe", pin_oe, 8'h00);
        chk("R2 pin_out", pin_out, 8'h00);
        chk("R2 pull_sel", pull_sel, 8'hFF);
        chk("R2 irq", {7'd0, irq}, 8'h00);
        read_all("R2 R8 default", 8'h00, 8'h00);

        // R3 R4: direction and output data
        write_reg(4, 8'hF0); m_cfg = 8'hF0;
        write_reg(5, 8'hA5); m_outp = 8'hA5;
        chk("R3 pin_oe", pin_oe, 8'h0F);
        chk("R4 pin_out partial", pin_out, 8'h05);
        write_reg(4, 8'h00); m_cfg = 8'h00;
        chk("R3 pin_oe all out", pin_oe, 8'hFF);
        chk("R4 pin_out revealed", pin_out, 8'hA5);

        // R1: upper command bits ignored, 0xFD selects pointer 5
        write_reg(8'hFD, 8'h3C); m_outp = 8'h3C;
        chk("R1 pin_out via 0xFD", pin_out, 8'h3C);
        read_reg(8'hE5, 8'h3C, "R1 read via 0xE5");

        // R5: polarity and synchronizer latency
        write_reg(1, 8'h0F); m_pol = 8'h0F;
        chk("R5 image before", in_image, 8'h0F);
        pin_in = 8'h5A;
        @(negedge clk);
        chk("R5 image one edge", in_image, 8'h0F);
        @(negedge clk);
        chk("R5 image two edges", in_image, 8'h55);
        read_reg(0, 8'h55, "R5 read image");

        // R6: writes to read-only pointers have no effect
        write_reg(0, 8'hFF);
        write_reg(7, 8'hFF);
        chk("R6 image kept", in_image, 8'h55);
        read_reg(7, 8'h00, "R6 status kept");
        read_reg(4, m_cfg, "R6 cfg kept");

        // R7: several data bytes to one register, pointer persists
        t_start; t_addr(0); t_byte(2); t_byte(8'h11); t_byte(8'h22); t_stop;
        m_pen = 8'h22;
        chk("R12 pull_en", pull_en, 8'h22);
        t_start; t_addr(1); t_req("R7 pointer kept", 8'h22); t_stop;
        write_reg(3, 8'h0F); m_psel = 8'h0F;
        chk("R12 pull_sel", pull_sel, 8'h0F);
        chk("R11 pull_en kept", pull_en, 8'h22);

        // R9: masked change does nothing, unmasked change raises irq
        write_reg(6, 8'hFC); m_mask = 8'hFC;
        pin_in = 8'hDA;
        repeat (4) @(negedge clk);
        chk("R9 masked change", {7'd0, irq}, 8'h00);
        pin_in = 8'hDB;
        repeat (2) @(negedge clk);
        chk("R9 irq two edges", {7'd0, irq}, 8'h00);
        @(negedge clk);
        chk("R9 irq three edges", {7'd0, irq}, 8'h01);
        read_reg(7, 8'h01, "R9 status bit0");

        // R10: clear-on-read colliding with a new change on bit 1
        t_start; t_addr(0); t_byte(0); t_start; t_addr(1);
        pin_in = 8'hD9;
        repeat (2) @(negedge clk);
        t_req("R10 collision read", 8'hD6);
        t_stop;
        chk("R10 irq kept", {7'd0, irq}, 8'h01);
        read_reg(7, 8'h02, "R10 status new bit only");
        read_reg(0, 8'hD6, "R10 clearing read");
        chk("R10 irq cleared", {7'd0, irq}, 8'h00);

        // R11: every register holds its own last write
        read_all("R11 final", 8'hD6, 8'h00);

        repeat (3) @(negedge clk);
        chk("R8 scoreboard drained", 8'(exp_q.size()), 8'h00);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule